// File: doc/BRIEF.md
# Reset Time-Out Sequencer

This block keeps the internal system reset asserted after a power-on pulse, a brown-out, the block's own reset or a wake from sleep. It releases the reset only when a chain of delay stages has expired. There are up to three stages, and they always run in this order. The first is a power-up delay counted in slow timebase ticks. The second is an oscillator settling count measured in oscillator clock cycles. The third is a PLL lock delay, also counted in slow ticks. The oscillator mode code, the power-up delay enable and the cause of the reset together decide which stages run.

An active-low external reset is combined with the sequence. Holding it low keeps the system in reset, but the delay stages continue to count while it is held. A wake event seen while the system runs asserts the reset again, but only for the oscillator settling count (plus the PLL delay when it applies). In non-crystal modes a wake event does nothing. All inputs are assumed to be synchronous to `clk`. The slow tick is a single-cycle enable pulse.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sys_rst` is 1 after that edge. After `rst_n` rises, the block runs the same sequence as after a power-on pulse.
- R2: Oscillator mode codes are: 0 low-power crystal, 1 crystal, 2 high-speed crystal, 3 high-speed crystal with PLL, 4 RC, 5 RC with spare pin, 6 external clock, 7 external clock with spare pin. Let E0 be the last edge at which `por_pulse` is high. `sys_rst` falls at edge E0+1+N, where N is the sum of the lengths of the enabled stages, and it stays 1 before that edge.
- R3: When `pwrt_en` is 0, the power-up stage (PWRT_TICKS ticks) is skipped. In modes 4 to 7 with `pwrt_en` 0, `sys_rst` falls one edge after E0.
- R4: The oscillator settling stage lasts OST_CYCLES clock cycles and runs only in modes 0 to 3.
- R5: In mode 3, a PLL lock stage of PLL_TICKS ticks follows the settling stage.
- R6: The power-up and PLL stages advance only on edges where `slow_tick` is 1.
- R7: While `bor_en` and `bor_low` are both 1, `sys_rst` is held at 1. After the last such edge, the whole sequence restarts from the beginning, as in R2, even if it was already part way through.
- R8: When `bor_en` is 0, `bor_low` has no effect.
- R9: A `wake_evt` pulse while `sys_rst` is 0 does two things depending on the mode. In modes 0 to 3 it asserts `sys_rst` for OST_CYCLES edges (plus PLL_TICKS ticks in mode 3). In modes 4 to 7 it leaves `sys_rst` at 0.
- R10: `ext_rst_n` low at an edge makes `sys_rst` 1 after that edge. The delay stages keep counting while it is low. When it is released after the stages have expired, `sys_rst` falls at the first edge where `ext_rst_n` is high.
- R11: A `wake_evt` pulse that arrives while a sequence is running does not change the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_pulse | input | 1 | Power-on detect pulse |
| bor_low | input | 1 | Supply below brown-out threshold (level) |
| bor_en | input | 1 | Brown-out reset enable configuration bit |
| ext_rst_n | input | 1 | External reset, active low |
| wake_evt | input | 1 | Wake-from-sleep or clock-switch event |
| slow_tick | input | 1 | Slow timebase enable pulse |
| osc_mode | input | 3 | Oscillator mode code |
| pwrt_en | input | 1 | Power-up delay enable configuration bit |
| sys_rst | output | 1 | Internal system reset, active high |

## Verification
A stage counter that is off by one moves the falling edge of `sys_rst` by exactly one cycle, so every release is checked at the exact edge and also at the edge before it. If the stage-selection logic is wrong, a stage is added or dropped, which shifts the release by a whole stage length (or removes the reset pulse entirely on a wake). A counter that is not cleared when the sequence restarts shows up as an early release after a brown-out that interrupts the power-up stage. Failing to count while the external reset is held shows up as a late release when that reset is let go.

// File: rtl/rst_to_pkg.sv
// Package: shared types and mode decoding for the reset time-out sequencer.
// Assumes mode codes 0..3 are crystal modes and code 3 adds a PLL.
package rst_to_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PWRT  = 3'd1,
        ST_OST   = 3'd2,
        ST_PLL   = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    localparam int STG_PWRT = 0;
    localparam int STG_OST  = 1;
    localparam int STG_PLL  = 2;
    localparam int NUM_STG  = 3;

    localparam logic [2:0] MODE_HS_PLL = 3'd3;

    // Crystal modes need the oscillator settling count.
    function automatic logic mode_is_xtal(input logic [2:0] mode);
        return ~mode[2];
    endfunction

    // Only the high-speed crystal with PLL mode needs the lock delay.
    function automatic logic mode_has_pll(input logic [2:0] mode);
        return mode == MODE_HS_PLL;
    endfunction

endpackage

// File: rtl/rst_to_timer.sv
// Stage timer: counts enabled steps while its stage is active and flags
// the step that completes LIMIT of them. Cleared whenever not enabled.
// Assumes 1 <= LIMIT <= 2**CNT_W.
module rst_to_timer #(
    parameter int CNT_W = 10,
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Count steps during the stage, restart from zero outside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Final step of the stage.
    always_comb begin
        done = en && step && (cnt == LAST);
    end

endmodule

// File: rtl/rst_to_events.sv
// Event decoder: merges the reset causes into a restart request and
// qualifies wake events. Assumes all inputs are synchronous to clk.
module rst_to_events (
    input  logic       por_pulse,
    input  logic       bor_low,
    input  logic       bor_en,
    input  logic       wake_evt,
    input  logic       running,
    input  logic [2:0] osc_mode,
    output logic       restart,
    output logic       wake_go
);
    import rst_to_pkg::*;

    logic bor_hit;

    // Brown-out counts only when enabled by configuration.
    always_comb begin
        bor_hit = bor_en && bor_low;
    end

    // Power-on or brown-out restarts the whole chain.
    always_comb begin
        restart = por_pulse || bor_hit;
    end

    // Wake re-enters the chain only from run state in crystal modes.
    always_comb begin
        wake_go = wake_evt && running && mode_is_xtal(osc_mode) && !restart;
    end

endmodule

// File: rtl/rst_to_fsm.sv
// Sequencer state machine: walks power-up, settling and PLL stages in
// order, skipping stages that the mode and configuration rule out, and
// drives the registered system reset. Assumes stage done flags are
// single-cycle and come from timers enabled by stage_en.
module rst_to_fsm
    import rst_to_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               wake_go,
    input  logic               pwrt_en,
    input  logic [2:0]         osc_mode,
    input  logic               ext_rst_n,
    input  logic [NUM_STG-1:0] stage_done,
    output logic [NUM_STG-1:0] stage_en,
    output logic               running,
    output logic               sys_rst
);
    seq_state_e state, nxt;
    seq_state_e first_stg, after_pwrt, after_ost;

    // Stage that follows each point in the chain for the current mode.
    always_comb begin
        after_ost  = mode_has_pll(osc_mode) ? ST_PLL : ST_RUN;
        after_pwrt = mode_is_xtal(osc_mode) ? ST_OST : ST_RUN;
        first_stg  = pwrt_en ? ST_PWRT : after_pwrt;
    end

    // Next-state selection; a restart overrides everything.
    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = ST_START;
        end else begin
            case (state)
                ST_START: nxt = first_stg;
                ST_PWRT:  if (stage_done[STG_PWRT]) nxt = after_pwrt;
                ST_OST:   if (stage_done[STG_OST])  nxt = after_ost;
                ST_PLL:   if (stage_done[STG_PLL])  nxt = ST_RUN;
                ST_RUN:   if (wake_go)              nxt = ST_OST;
                default:  nxt = ST_START;
            endcase
        end
    end

    // State and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_START;
            sys_rst <= 1'b1;
        end else begin
            state   <= nxt;
            sys_rst <= (nxt != ST_RUN) || !ext_rst_n;
        end
    end

    // Stage enables for the timers.
    always_comb begin
        stage_en           = '0;
        stage_en[STG_PWRT] = (state == ST_PWRT);
        stage_en[STG_OST]  = (state == ST_OST);
        stage_en[STG_PLL]  = (state == ST_PLL);
        running            = (state == ST_RUN);
    end

endmodule

// File: rtl/rst_timeout_seq.sv
// Top: reset time-out sequencer. Holds sys_rst after power-on, brown-out,
// block reset or wake until the selected delay stages expire. Power-up
// and PLL stages count slow_tick pulses; the settling stage counts clk.
// Assumes synchronous inputs and static configuration bits.
module rst_timeout_seq #(
    parameter int CNT_W      = 10,
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_pulse,
    input  logic       bor_low,
    input  logic       bor_en,
    input  logic       ext_rst_n,
    input  logic       wake_evt,
    input  logic       slow_tick,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en,
    output logic       sys_rst
);
    import rst_to_pkg::*;

    logic                restart;
    logic                wake_go;
    logic                running;
    logic [NUM_STG-1:0]  stage_en;
    logic [NUM_STG-1:0]  stage_done;

    rst_to_events u_evt (
        .por_pulse (por_pulse),
        .bor_low   (bor_low),
        .bor_en    (bor_en),
        .wake_evt  (wake_evt),
        .running   (running),
        .osc_mode  (osc_mode),
        .restart   (restart),
        .wake_go   (wake_go)
    );

    rst_to_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .wake_go    (wake_go),
        .pwrt_en    (pwrt_en),
        .osc_mode   (osc_mode),
        .ext_rst_n  (ext_rst_n),
        .stage_done (stage_done),
        .stage_en   (stage_en),
        .running    (running),
        .sys_rst    (sys_rst)
    );

    // One timer per stage; the settling stage steps every clock.
    for (genvar gi = 0; gi < NUM_STG; gi++) begin : g_stage
        localparam int LIM = (gi == STG_PWRT) ? PWRT_TICKS :
                             (gi == STG_OST)  ? OST_CYCLES : PLL_TICKS;
        logic step;
        assign step = (gi == STG_OST) ? 1'b1 : slow_tick;

        rst_to_timer #(
            .CNT_W (CNT_W),
            .LIMIT (LIM)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (stage_en[gi]),
            .step  (step),
            .done  (stage_done[gi])
        );
    end

endmodule

// File: rtl/rst_timeout_chk.sv
// Checker for the reset time-out sequencer, bound to the top module.
module rst_timeout_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_pulse,
    input logic       bor_low,
    input logic       bor_en,
    input logic       ext_rst_n,
    input logic       wake_evt,
    input logic [2:0] osc_mode,
    input logic [2:0] stage_en,
    input logic       sys_rst
);
    AST_BLOCK_RST_HOLD: assert property (@(posedge clk)
        !rst_n |=> sys_rst); // R1

    AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> sys_rst); // R2

    AST_SINGLE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_en)); // R2

    AST_BOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bor_en && bor_low) |=> sys_rst); // R7

    AST_WAKE_NO_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !sys_rst && osc_mode[2] && ext_rst_n && !por_pulse
         && !(bor_en && bor_low)) |=> !sys_rst); // R9

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |=> sys_rst); // R10

    AST_RELEASE_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> $past(ext_rst_n)); // R10

endmodule

bind rst_timeout_seq rst_timeout_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_pulse (por_pulse),
    .bor_low   (bor_low),
    .bor_en    (bor_en),
    .ext_rst_n (ext_rst_n),
    .wake_evt  (wake_evt),
    .osc_mode  (osc_mode),
    .stage_en  (stage_en),
    .sys_rst   (sys_rst)
);

// File: tb/rst_timeout_seq_tb.sv
`timescale 1ns/1ps
module rst_timeout_seq_tb;
    localparam int P = 6;
    localparam int O = 20;
    localparam int L = 4;
    localparam int NV = 10;

    // Stimulus {mode[5:3], pwrt_en[2], cause[1:0]}; cause 0 por, 1 bor, 2 wake.
    localparam logic [5:0] VEC_STIM [NV] = '{
        {3'd0, 1'b1, 2'd0}, {3'd1, 1'b0, 2'd0}, {3'd2, 1'b1, 2'd1},
        {3'd3, 1'b1, 2'd0}, {3'd3, 1'b0, 2'd2}, {3'd4, 1'b0, 2'd0},
        {3'd6, 1'b1, 2'd1}, {3'd7, 1'b0, 2'd2}, {3'd5, 1'b1, 2'd0},
        {3'd1, 1'b1, 2'd2}
    };
    // Expected edges from the trigger edge to the release edge (0 = none).
    localparam int VEC_LEN [NV] = '{
        1+P+O, 1+O, 1+P+O, 1+P+O+L, O+L, 1, 1+P, 0, 1+P, O
    };
    localparam string VEC_TAG [NV] = '{
        "R4", "R3", "R7", "R5", "R9", "R3", "R7", "R9", "R2", "R9"
    };

    logic       clk = 1'b0;
    logic       rst_n, por_pulse, bor_low, bor_en, ext_rst_n;
    logic       wake_evt, slow_tick, pwrt_en;
    logic [2:0] osc_mode;
    logic       sys_rst;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    rst_timeout_seq #(
        .CNT_W(10), .PWRT_TICKS(P), .OST_CYCLES(O), .PLL_TICKS(L)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .bor_low(bor_low),
        .bor_en(bor_en), .ext_rst_n(ext_rst_n), .wake_evt(wake_evt),
        .slow_tick(slow_tick), .osc_mode(osc_mode), .pwrt_en(pwrt_en),
        .sys_rst(sys_rst)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (sys_rst !== exp) begin
            n_bad++;
            $display("FAIL %s: sys_rst=%0b expected %0b", tag, sys_rst, exp);
        end
    endtask

    // Pulse one cause for a single edge (that edge is the trigger edge).
    task automatic trigger(input int cause);
        if (cause == 0) por_pulse = 1'b1;
        else if (cause == 1) bor_low = 1'b1;
        else wake_evt = 1'b1;
        step();
        por_pulse = 1'b0;
        bor_low   = 1'b0;
        wake_evt  = 1'b0;
    endtask

    // Called just after the trigger edge: high until edge len, low after it.
    task automatic expect_release(input int len, input string tag);
        for (int k = 1; k < len; k++) step();
        check(1'b1, tag);
        step();
        check(1'b0, tag);
    endtask

    task automatic settle();
        trigger(0);
        repeat (40) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: run active expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_pulse = 1'b0; bor_low = 1'b0; bor_en = 1'b1;
        ext_rst_n = 1'b1; wake_evt = 1'b0; slow_tick = 1'b1;
        osc_mode = 3'd6; pwrt_en = 1'b0;
        @(negedge clk);
        step();
        check(1'b1, "R1");
        rst_n = 1'b1;
        // last low edge just passed; EC, no power-up delay: one edge
        step();
        check(1'b0, "R1");

        // Table walk: all modes and causes with slow_tick held high.
        for (int v = 0; v < NV; v++) begin
            osc_mode = VEC_STIM[v][5:3];
            pwrt_en  = VEC_STIM[v][2];
            settle();
            check(1'b0, "R2");
            trigger(int'(VEC_STIM[v][1:0]));
            if (VEC_LEN[v] == 0) begin
                check(1'b0, VEC_TAG[v]);
                repeat (4) step();
                check(1'b0, VEC_TAG[v]);
            end else begin
                expect_release(VEC_LEN[v], VEC_TAG[v]);
            end
        end

        // R6: power-up stage counts slow ticks only.
        osc_mode = 3'd4; pwrt_en = 1'b1; slow_tick = 1'b0;
        trigger(0);
        step();
        for (int t = 1; t <= P; t++) begin
            repeat (2) step();
            check(1'b1, "R6");
            slow_tick = 1'b1;
            step();
            slow_tick = 1'b0;
        end
        check(1'b0, "R6");
        slow_tick = 1'b1;

        // R7: brown-out part way through the power-up stage restarts it.
        osc_mode = 3'd2; pwrt_en = 1'b1;
        trigger(0);
        repeat (4) step();
        bor_low = 1'b1;
        step();
        check(1'b1, "R7");
        trigger(1);
        expect_release(1 + P + O, "R7");

        // R8: brown-out ignored when disabled.
        bor_en = 1'b0; bor_low = 1'b1;
        repeat (6) step();
        check(1'b0, "R8");
        bor_low = 1'b0; bor_en = 1'b1;

        // R10: external reset asserts at the next edge.
        ext_rst_n = 1'b0;
        step();
        check(1'b1, "R10");
        // R10: held past the time-outs, release is immediate.
        trigger(0);
        repeat (60) step();
        check(1'b1, "R10");
        ext_rst_n = 1'b1;
        step();
        check(1'b0, "R10");

        // R11: wake during a running sequence leaves the release edge alone.
        osc_mode = 3'd1; pwrt_en = 1'b0;
        trigger(0);
        for (int k = 1; k < 1 + O; k++) begin
            wake_evt = (k == 5);
            step();
        end
        wake_evt = 1'b0;
        check(1'b1, "R11");
        step();
        check(1'b0, "R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule